// File: doc/BRIEF.md
# Amplifier Control Port: I2C Slave Register Interface

This block is the serial control port of a four-channel amplifier controller. It acts only as an I2C slave. A system clock runs at least eight times faster than SCL and samples both bus lines. The block finds start and stop conditions, matches its own bus address, acknowledges bytes and shifts data in and out. It drives SDA only by pulling it low, and an outside pull-up returns the line high.

The block holds an 8-bit subaddress pointer. A write transaction sends the subaddress and then any number of data bytes, and the pointer steps by one after each byte. A read works in one of two ways. The first is a subaddress write, a repeated start and a read, which returns bytes from that subaddress on. The second is a read with no new subaddress, which continues from wherever the pointer was left. The pointer also steps after every byte that is read out.

The register space has two regions. Status bytes come from a parallel input bus and are read-only. Control bytes are stored here and appear on a parallel output bus. All other addresses are unused.

Top module: `amp_ctl_i2c_port`

## Requirements
- R1: The device address byte is binary 11011, then `strap_sel[1]`, `strap_sel[0]`, then R/W (1 = read). The write/read pairs are 0xD8/0xD9, 0xDA/0xDB, 0xDC/0xDD and 0xDE/0xDF for strap values 0 to 3. A matching address byte is acknowledged.
- R2: A device address byte that does not match is not acknowledged. No later byte is acknowledged and no register changes until the next start condition.
- R3: For every accepted received byte (device address, subaddress, data), the slave holds SDA low during the ninth SCL clock and releases it after that clock falls.
- R4: In a write transaction, the byte after the device address loads the pointer. Each following data byte, received MSB first, is written at the pointer.
- R5: The pointer advances by one after every data byte, whether written or read. It wraps from 0xFF to 0x00.
- R6: After a device address with R/W = 1, the slave sends bytes MSB first, starting at the current pointer. This covers both the subaddress, repeated start, read sequence and a bare read that continues from the previous pointer.
- R7: Reads of 0x00 to 0x07 return `status_bus` bytes 0 to 7. A read of 0x13 returns byte 8. Byte k sits at bits 8k+7:8k.
- R8: Control addresses 0x08 to 0x0D map to `ctrl_bus` bytes 0 to 5, and 0x10 maps to byte 6. Byte k sits at bits 8k+7:8k. Control bytes read back what was last written, and every control byte resets to 0x00.
- R9: A data byte written to a status address or an unused address is acknowledged and discarded.
- R10: Reads of unused addresses (0x0E, 0x0F, 0x11, 0x12, 0x14 to 0xFF) return 0x00.
- R11: When the master answers a read byte with NACK, the slave stops sending and leaves SDA released.
- R12: A stop or start condition at any point, including in the middle of a byte, sends the slave back to idle or to address reception. SDA is released, and a partly received byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| strap_sel | input | 2 | Selects the two low bits of the bus address |
| status_bus | input | 72 | Nine read-only status bytes |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| ctrl_bus | output | 56 | Seven stored control bytes |

## Verification
The hardest conditions to reach from the ports are bus conditions that cut a byte short: a stop or a repeated start after only a few data bits, and a read that continues into the next byte or wraps past 0xFF. The bench's bit-level master tasks can emit any prefix of a byte before a start or stop. Directed cases use them for truncated writes, a repeated start inside a data byte and a read that begins at 0xFF. Random transactions then mix strap values, start addresses spread around the region borders, burst lengths and directions. Every byte is compared against a model of the register space that the bench keeps for itself.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK
  } link_state_t;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_STATUS,
    RK_CTRL
  } reg_kind_t;

  // Region of a subaddress.
  function automatic reg_kind_t reg_kind(input logic [7:0] a);
    if (a <= 8'h07 || a == 8'h13) return RK_STATUS;
    if ((a >= 8'h08 && a <= 8'h0D) || a == 8'h10) return RK_CTRL;
    return RK_NONE;
  endfunction

  // Status byte slot: 0x00..0x07 -> 0..7, 0x13 -> 8.
  function automatic logic [3:0] status_slot(input logic [7:0] a);
    return (a == 8'h13) ? 4'd8 : a[3:0];
  endfunction

  // Control byte slot: 0x08..0x0D -> 0..5, 0x10 -> 6.
  function automatic logic [2:0] ctrl_slot(input logic [7:0] a);
    logic [3:0] d;
    d = a[3:0] - 4'd8;
    return (a == 8'h10) ? 3'd6 : d[2:0];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic ev_scl_rise,
  output logic ev_scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic [STAGES-1:0] scl_ch, sda_ch;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[STAGES-2:0], scl_i};
      sda_ch <= {sda_ch[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s       = scl_ch[STAGES-1];
  assign sda_s       = sda_ch[STAGES-1];
  assign sda_lvl     = sda_s;
  assign ev_scl_rise = scl_s & ~scl_q;
  assign ev_scl_fall = ~scl_s & scl_q;
  assign ev_start    = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_link_ctrl.sv
module i2c_link_ctrl
  import amp_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_sel,
  input  logic       sda_lvl,
  input  logic       ev_scl_rise,
  input  logic       ev_scl_fall,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_drive_low
);

  link_state_t st, next_st;
  logic [3:0]  cnt;
  logic [7:0]  sh, tx;
  logic        m_ack;

  wire byte_full = (cnt == 4'd8);
  wire addr_hit  = (sh[7:1] == {ADDR_PREFIX, strap_sel});
  wire addr_miss = (st == ST_ADDR) && ev_scl_fall && byte_full && !addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      next_st       <= ST_IDLE;
      cnt           <= '0;
      sh            <= '0;
      tx            <= '0;
      m_ack         <= 1'b0;
      ptr           <= '0;
      wr_stb        <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
      sda_drive_low <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (ev_start) begin
        st            <= ST_ADDR;
        cnt           <= '0;
        sda_drive_low <= 1'b0;
      end else if (ev_stop) begin
        st            <= ST_IDLE;
        cnt           <= '0;
        sda_drive_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (ev_scl_rise && !byte_full) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (ev_scl_fall && byte_full) begin
              cnt <= '0;
              case (st)
                ST_ADDR: begin
                  if (addr_hit) begin
                    sda_drive_low <= 1'b1;
                    next_st       <= sh[0] ? ST_TX : ST_SUB;
                    st            <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_SUB: begin
                  ptr           <= sh;
                  sda_drive_low <= 1'b1;
                  next_st       <= ST_WDATA;
                  st            <= ST_ACK;
                end
                default: begin
                  wr_stb        <= 1'b1;
                  wr_addr       <= ptr;
                  wr_data       <= sh;
                  ptr           <= ptr + 8'd1;
                  sda_drive_low <= 1'b1;
                  next_st       <= ST_WDATA;
                  st            <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (ev_scl_fall) begin
              st  <= next_st;
              cnt <= '0;
              if (next_st == ST_TX) begin
                tx            <= rd_data;
                sda_drive_low <= ~rd_data[7];
              end else begin
                sda_drive_low <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (ev_scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (ev_scl_fall) begin
              if (byte_full) begin
                sda_drive_low <= 1'b0;
                ptr           <= ptr + 8'd1;
                cnt           <= '0;
                st            <= ST_RACK;
              end else begin
                tx            <= {tx[6:0], 1'b0};
                sda_drive_low <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (ev_scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (ev_scl_fall) begin
              if (m_ack) begin
                tx            <= rd_data;
                sda_drive_low <= ~rd_data[7];
                st            <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  drive_only_when_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> (st == ST_ACK || st == ST_TX));

  // R12
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_drive_low && st == ST_IDLE));

  // R12
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st == ST_ADDR && cnt == 4'd0));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ptr == wr_addr + 8'd1));

  // R2
  mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_miss && !ev_start && !ev_stop) |=> (st == ST_IDLE && !sda_drive_low));

endmodule

// File: rtl/amp_reg_bank.sv
module amp_reg_bank
  import amp_i2c_pkg::*;
#(
  parameter int STAT_N = 9,
  parameter int CTRL_N = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  input  logic [STAT_N*8-1:0]   status_bus,
  output logic [7:0]            rd_data,
  output logic [CTRL_N*8-1:0]   ctrl_bus
);

  localparam int CSLOT_W = $clog2(CTRL_N);

  logic [7:0] ctrl_q [CTRL_N];
  wire        wr_ctrl = wr_stb && (reg_kind(wr_addr) == RK_CTRL);
  wire [2:0]  wr_slot = ctrl_slot(wr_addr);

  for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[g] <= '0;
      else if (wr_ctrl && wr_slot[CSLOT_W-1:0] == CSLOT_W'(g)) ctrl_q[g] <= wr_data;
    end
    assign ctrl_bus[g*8 +: 8] = ctrl_q[g];
  end

  always_comb begin
    case (reg_kind(rd_addr))
      RK_STATUS: rd_data = status_bus[int'(status_slot(rd_addr))*8 +: 8];
      RK_CTRL:   rd_data = ctrl_q[int'(ctrl_slot(rd_addr))];
      default:   rd_data = 8'h00;
    endcase
  end

  // R9
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_kind(wr_addr) != RK_CTRL) |=> $stable(ctrl_bus));

  // R8
  ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_bus[int'($past(wr_slot))*8 +: 8] == $past(wr_data)));

endmodule

// File: rtl/amp_ctl_i2c_port.sv
module amp_ctl_i2c_port
  import amp_i2c_pkg::*;
#(
  parameter int         STAT_N      = 9,
  parameter int         CTRL_N      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b11011
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [1:0]          strap_sel,
  input  logic [STAT_N*8-1:0] status_bus,
  output logic                sda_drive_low,
  output logic [CTRL_N*8-1:0] ctrl_bus
);

  logic       sda_lvl, ev_scl_rise, ev_scl_fall, ev_start, ev_stop;
  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic       wr_stb;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_lvl     (sda_lvl),
    .ev_scl_rise (ev_scl_rise),
    .ev_scl_fall (ev_scl_fall),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop)
  );

  i2c_link_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) u_link (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_sel     (strap_sel),
    .sda_lvl       (sda_lvl),
    .ev_scl_rise   (ev_scl_rise),
    .ev_scl_fall   (ev_scl_fall),
    .ev_start      (ev_start),
    .ev_stop       (ev_stop),
    .rd_data       (rd_data),
    .ptr           (ptr),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .sda_drive_low (sda_drive_low)
  );

  amp_reg_bank #(.STAT_N(STAT_N), .CTRL_N(CTRL_N)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (ptr),
    .status_bus (status_bus),
    .rd_data    (rd_data),
    .ctrl_bus   (ctrl_bus)
  );

endmodule

// File: tb/test_amp_ctl_i2c_port.sv
module test_amp_ctl_i2c_port;

  localparam int QTR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [1:0]  strap = 2'd0;
  logic [71:0] stat = '0;
  wire  [55:0] ctrl;
  wire         sda_oe;
  wire         sda_bus = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mctl [7];

  always #2 clk = ~clk;

  amp_ctl_i2c_port i_amp_ctl_i2c_port (
    .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_bus),
    .strap_sel (strap), .status_bus (stat),
    .sda_drive_low (sda_oe), .ctrl_bus (ctrl)
  );

  function automatic int ctrl_idx(input int a);
    if (a >= 8 && a <= 13) return a - 8;
    if (a == 16) return 6;
    return -1;
  endfunction

  function automatic int stat_idx(input int a);
    if (a >= 0 && a <= 7) return a;
    if (a == 19) return 8;
    return -1;
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (stat_idx(a) >= 0) return stat[stat_idx(a)*8 +: 8];
    if (ctrl_idx(a) >= 0) return mctl[ctrl_idx(a)];
    return 8'h00;
  endfunction

  function automatic logic [55:0] exp_ctrl();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = mctl[k];
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(); m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_q(); m_scl = 1'b1; wait_q(); wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q(); b = sda_bus; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~ack);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
    return {4'hD, 1'b1, s, rw};
  endfunction

  task automatic do_write(input int sub, input int len);
    logic ak;
    int p;
    logic [7:0] d;
    bus_start();
    wr_byte(dev(strap, 1'b0), ak); check("R1 write address ack", ak, 1'b1);
    wr_byte(8'(sub), ak);          check("R3 subaddress ack", ak, 1'b1);
    p = sub;
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      wr_byte(d, ak);
      if (ctrl_idx(p) >= 0) check("R3 data ack", ak, 1'b1);
      else check("R9 discarded byte still acked", ak, 1'b1);
      if (ctrl_idx(p) >= 0) mctl[ctrl_idx(p)] = d;
      p = (p + 1) % 256;
    end
    bus_stop();
    check("R4 R5 R8 R9 control bus after write", ctrl, exp_ctrl());
  endtask

  task automatic read_from(input int start_p, input int len, input logic fresh_sub, input int sub);
    logic ak;
    logic [7:0] v;
    int p;
    bus_start();
    if (fresh_sub) begin
      wr_byte(dev(strap, 1'b0), ak); check("R1 address ack", ak, 1'b1);
      wr_byte(8'(sub), ak);          check("R3 subaddress ack", ak, 1'b1);
      bus_start();
    end
    wr_byte(dev(strap, 1'b1), ak); check("R1 read address ack", ak, 1'b1);
    p = start_p;
    for (int i = 0; i < len; i++) begin
      rd_byte(v, i != len - 1);
      if (stat_idx(p) >= 0) check("R7 R6 status read", v, exp_read(p));
      else if (ctrl_idx(p) >= 0) check("R8 R6 control read", v, exp_read(p));
      else check("R10 unused reads zero", v, exp_read(p));
      p = (p + 1) % 256;
    end
    check("R11 SDA released after NACK", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic ak;
    logic [55:0] snap;
    void'($urandom(32'd2718));
    for (int k = 0; k < 7; k++) mctl[k] = 8'h00;
    stat = {$urandom, $urandom, $urandom};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 control reset value", ctrl, 56'h0);
    check("R3 SDA idle after reset", sda_oe, 1'b0);

    // R1: every strap value answers at its own address
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      do_write(8 + s, 1);
    end

    // R2: wrong address gets no ack and no write
    strap = 2'd1;
    snap = ctrl;
    bus_start();
    wr_byte(dev(2'd2, 1'b0), ak); check("R2 foreign address not acked", ak, 1'b0);
    wr_byte(8'h08, ak);           check("R2 later byte not acked", ak, 1'b0);
    wr_byte(8'h5A, ak);           check("R2 later data not acked", ak, 1'b0);
    bus_stop();
    check("R2 control bus unchanged", ctrl, snap);

    // R5 R9: burst across unused gap into 0x10
    do_write(8'h0C, 5);
    // R9: writes to status addresses discarded, read shows status
    do_write(8'h06, 3);
    do_write(8'h13, 1);
    read_from(8'h13, 1, 1'b1, 8'h13);
    read_from(8'h06, 3, 1'b1, 8'h06);

    // R5: read pointer wraps 0xFF -> 0x00
    read_from(8'hFF, 2, 1'b1, 8'hFF);
    // R6: bare read continues at the pointer (0x01 after the wrap read)
    read_from(8'h01, 2, 1'b0, 0);

    // R12: stop in the middle of a data byte drops it
    snap = ctrl;
    bus_start();
    wr_byte(dev(strap, 1'b0), ak);
    wr_byte(8'h09, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check("R12 truncated byte dropped on stop", ctrl, snap);
    check("R12 SDA released after stop", sda_oe, 1'b0);

    // R12: repeated start in the middle of a data byte
    bus_start();
    wr_byte(dev(strap, 1'b0), ak);
    wr_byte(8'h0A, ak);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    wr_byte(dev(strap, 1'b0), ak); check("R12 address after restart acked", ak, 1'b1);
    wr_byte(8'h0B, ak);
    wr_byte(8'hC3, ak); check("R12 data after restart acked", ak, 1'b1);
    bus_stop();
    mctl[3] = 8'hC3;
    check("R12 only the full byte landed", ctrl, exp_ctrl());

    // random mix
    for (int t = 0; t < 30; t++) begin
      int pick, sub, len;
      strap = 2'($urandom % 4);
      if (t % 10 == 5) stat = {$urandom, $urandom, $urandom};
      pick = int'($urandom % 22);
      sub = (pick == 21) ? 8'hFE : pick;
      len = 1 + int'($urandom % 3);
      if ($urandom % 2 == 0) do_write(sub, len);
      else read_from(sub, len, 1'b1, sub);
    end

    report();
    $finish;
  end

endmodule